// File: doc/BRIEF.md
# CRC-32C Running Accumulator

This block advances a 32-bit cyclic redundancy check over one data operand per operation, using the Castagnoli generator polynomial 0x11EDC6F41 (the one used for iSCSI). Each operation takes an old CRC value, a 64-bit data word and a size code. The size code selects how many low-order bytes of the word are folded in: 1, 2, 4 or 8. All of the selected bytes are absorbed in a single step.

The new CRC is placed in the low half of a 64-bit result, and the high half is zero. It appears one clock after the request, together with a one-cycle completion strobe.

A caller walks a buffer by feeding the previous result back as the next old CRC, one word per operation. The caller chooses the seed and decides whether to invert the final value. The unit itself only performs the raw polynomial division.

Top module: `crc32c_acc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `crc_out` becomes 0 and `done` becomes 0.
- R2: The arithmetic is reflected. Data bits are taken least significant first, and the register is divided by the reflected polynomial 0x82F63B78. An 8-bit operation (`op_size` = 0) folds in `data_in[7:0]`.
- R3: A 16-bit operation (`op_size` = 1) folds in `data_in[7:0]` first and then `data_in[15:8]`.
- R4: A 32-bit operation (`op_size` = 2) folds in the four bytes of `data_in[31:0]`, lowest byte first.
- R5: A 64-bit operation (`op_size` = 3) folds in all eight bytes of `data_in`, lowest byte first.
- R6: Bits of `data_in` above the selected operand width have no effect on the result.
- R7: `crc_out[63:32]` is always zero.
- R8: `op_valid` high at a rising edge gives the new CRC and `done` = 1 right after that edge. `done` is 0 after any edge where `op_valid` was low.
- R9: `crc_out` holds its value across an edge where `op_valid` is low, whatever the other inputs do.
- R10: No seed and no final XOR are applied. An old CRC of 0 with all-zero data gives 0.
- R11: Seed with 0xFFFFFFFF, stream the ASCII bytes "123456789" one byte per operation with feedback, and invert the final value. The result is 0xE3069283.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Starts one update operation |
| op_size | input | 2 | Operand width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| crc_in | input | 32 | Old CRC value |
| data_in | input | 64 | Data word; bytes are consumed from the lowest up |
| crc_out | output | 64 | New CRC in bits 31:0, with bits 63:32 zero |
| done | output | 1 | One-cycle strobe marking a fresh result |

## Verification
Two things can land on the same edge: the completion of one operation (`done` and a fresh `crc_out`) and the launch of the next operation, whose old CRC is that same fresh result. The bench provokes this by streaming operations back to back. It keeps `op_valid` high on every cycle, with `crc_in` taken from `crc_out` at the falling edge, and mixes operand sizes within the stream. A behavioural table-driven model predicts both outputs for every clock. A stale or skipped feedback value would change the final check value and every intermediate comparison.

// File: rtl/crc32c_pkg.sv
// Shared constants and the operand-size encoding for the CRC-32C accumulator.
// Assumes reflected (LSB-first) processing throughout.
package crc32c_pkg;
    localparam int CRC_W      = 32;
    localparam int DATA_W     = 64;
    localparam int DEST_W     = 64;
    localparam int NBYTES     = DATA_W / 8;
    localparam int IDX_W      = $clog2(NBYTES);
    localparam logic [CRC_W-1:0] POLY_REFL = 32'h82F6_3B78;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } op_size_e;
endpackage

// File: rtl/crc32c_byte_step.sv
// Folds one byte into a reflected CRC: XOR into the low byte, then eight
// conditional shift-and-subtract steps. Purely combinational.
module crc32c_byte_step
    import crc32c_pkg::*;
(
    input  logic [CRC_W-1:0] crc_i,
    input  logic [7:0]       byte_i,
    output logic [CRC_W-1:0] crc_o
);
    // Eight serial division steps on the merged value.
    always_comb begin
        logic [CRC_W-1:0] c;
        c = crc_i ^ {{(CRC_W-8){1'b0}}, byte_i};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ POLY_REFL) : (c >> 1);
        end
        crc_o = c;
    end
endmodule

// File: rtl/crc32c_lane_chain.sv
// Chain of byte steps over the data word, lowest byte first. Tap k holds the
// CRC after bytes 0..k have been absorbed. Assumes NBYTES >= 1.
module crc32c_lane_chain
    import crc32c_pkg::*;
(
    input  logic [CRC_W-1:0]              crc_i,
    input  logic [DATA_W-1:0]             data_i,
    output logic [NBYTES-1:0][CRC_W-1:0]  tap_o
);
    genvar k;
    generate
        for (k = 0; k < NBYTES; k++) begin : g_step
            logic [CRC_W-1:0] stage_in;
            if (k == 0) begin : g_first
                assign stage_in = crc_i;
            end else begin : g_next
                assign stage_in = tap_o[k-1];
            end
            crc32c_byte_step u_step (
                .crc_i  (stage_in),
                .byte_i (data_i[8*k +: 8]),
                .crc_o  (tap_o[k])
            );
        end
    endgenerate
endmodule

// File: rtl/crc32c_size_sel.sv
// Picks the chain tap matching the operand width: the tap after 1, 2, 4 or
// 8 bytes. Assumes the size code never names more bytes than the chain has.
module crc32c_size_sel
    import crc32c_pkg::*;
(
    input  logic [NBYTES-1:0][CRC_W-1:0] tap_i,
    input  logic [1:0]                   size_i,
    output logic [CRC_W-1:0]             crc_o
);
    logic [IDX_W-1:0] last_idx;

    // Index of the last absorbed byte: 2^size - 1.
    always_comb begin
        last_idx = IDX_W'((1 << size_i) - 1);
        crc_o    = tap_i[last_idx];
    end
endmodule

// File: rtl/crc32c_acc.sv
// CRC-32C accumulator top level. It registers one update per op_valid and
// zero-extends the result into a 64-bit destination. Seeding and final
// inversion are left to the caller. Synchronous active-low reset.
module crc32c_acc
    import crc32c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_size,
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DEST_W-1:0] crc_out,
    output logic              done
);
    logic [NBYTES-1:0][CRC_W-1:0] taps;
    logic [CRC_W-1:0]             next_crc;

    crc32c_lane_chain u_chain (
        .crc_i  (crc_in),
        .data_i (data_in),
        .tap_o  (taps)
    );

    crc32c_size_sel u_sel (
        .tap_i  (taps),
        .size_i (op_size),
        .crc_o  (next_crc)
    );

    // Result register: load on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_out <= '0;
        end else if (op_valid) begin
            crc_out <= {{(DEST_W-CRC_W){1'b0}}, next_crc};
        end
    end

    // Completion strobe: one cycle per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= op_valid;
        end
    end
endmodule

// File: rtl/crc32c_acc_chk.sv
// Protocol checker for crc32c_acc, attached by bind. It observes ports only.
module crc32c_acc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [31:0] crc_in,
    input logic [63:0] data_in,
    input logic [63:0] crc_out,
    input logic        done
);
    // R7: high half of the destination stays zero.
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        crc_out[63:32] == 32'h0);

    // R8: a request is followed by the strobe.
    a_r8_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    // R8: no strobe without a request.
    a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    // R9: the result holds while idle.
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(crc_out));

    // R10: zero in, zero out, since no seed or final XOR is applied.
    a_r10_zero_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && crc_in == 32'h0 && data_in == 64'h0) |=> crc_out == 64'h0);
endmodule

bind crc32c_acc crc32c_acc_chk u_chk (.*);

// File: tb/crc32c_acc_test.sv
`timescale 1ns/1ps
// Self-checking bench: a table-driven behavioural model is compared on every clock.
module crc32c_acc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic [31:0] crc_in = 32'h0;
    logic [63:0] data_in = 64'h0;
    logic [63:0] crc_out;
    logic        done;

    int    checks = 0;
    int    errors = 0;
    bit    running = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    logic [31:0] tab [256];
    logic [63:0] exp_out;
    logic        exp_done;

    crc32c_acc uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_size(op_size),
        .crc_in(crc_in), .data_in(data_in), .crc_out(crc_out), .done(done)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [63:0] d,
                                            input logic [1:0] sz);
        int n = 1 << sz;
        for (int i = 0; i < n; i++) begin
            logic [7:0] idx;
            idx = c[7:0] ^ d[8*i +: 8];
            c = (c >> 8) ^ tab[idx];
        end
        return c;
    endfunction

    task automatic report(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Reference model: next expected outputs from the inputs seen at the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_out  <= 64'h0;
            exp_done <= 1'b0;
        end else if (op_valid) begin
            exp_out  <= {32'h0, ref_crc(crc_in, data_in, op_size)};
            exp_done <= 1'b1;
        end else begin
            exp_done <= 1'b0;
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            report(cur_req, crc_out, exp_out);
            report({cur_req, "/R8 done"}, {63'h0, done}, {63'h0, exp_done});
        end
    end

    task automatic step(input bit v, input logic [1:0] sz, input logic [31:0] c,
                        input logic [63:0] d);
        @(negedge clk);
        op_valid = v; op_size = sz; crc_in = c; data_in = d;
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] r_clean, r_junk, final_c;
        string       s = "123456789";

        for (int i = 0; i < 256; i++) begin
            logic [31:0] v;
            v = 32'(i);
            for (int b = 0; b < 8; b++) v = v[0] ? ((v >> 1) ^ 32'h82F63B78) : (v >> 1);
            tab[i] = v;
        end

        // R1: reset state.
        cur_req = "R1";
        repeat (2) @(posedge clk);
        running = 1'b1;
        @(negedge clk);
        report("R1 reset crc", crc_out, 64'h0);
        report("R1 reset done", {63'h0, done}, 64'h0);
        rst_n = 1'b1;

        // R10: zero operand with zero CRC.
        cur_req = "R10";
        step(1, 2'd3, 32'h0, 64'h0);
        idle();
        report("R10 zero", crc_out, 64'h0);

        // R2: single bytes, known value: 0x00 from all-ones.
        cur_req = "R2";
        step(1, 2'd0, 32'hFFFFFFFF, 64'h0);
        idle();
        report("R2 byte 00", crc_out, {32'h0, ref_crc(32'hFFFFFFFF, 64'h0, 2'd0)});
        for (int i = 0; i < 6; i++) step(1, 2'd0, $urandom, {$urandom, $urandom});

        // R9: idle with changing inputs.
        cur_req = "R9";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            op_valid = 1'b0; crc_in = $urandom; data_in = {$urandom, $urandom};
            op_size = 2'($urandom);
        end

        // R3, R4, R5: each width, isolated and then streamed.
        cur_req = "R3";
        for (int i = 0; i < 5; i++) step(1, 2'd1, $urandom, {$urandom, $urandom});
        cur_req = "R4";
        for (int i = 0; i < 5; i++) step(1, 2'd2, $urandom, {$urandom, $urandom});
        cur_req = "R5";
        for (int i = 0; i < 5; i++) step(1, 2'd3, $urandom, {$urandom, $urandom});
        idle();

        // R5 with feedback: back-to-back mixed sizes, old CRC taken from output.
        cur_req = "R5 stream";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            op_valid = 1'b1; op_size = 2'(i % 4);
            crc_in = crc_out[31:0]; data_in = {$urandom, $urandom};
        end
        idle();

        // R6: junk above operand width must not matter.
        cur_req = "R6";
        for (int sz = 0; sz < 3; sz++) begin
            logic [63:0] lo_mask;
            logic [63:0] d;
            lo_mask = (64'h1 << (8 << sz)) - 64'h1;
            d = {$urandom, $urandom};
            step(1, 2'(sz), 32'h1234ABCD, d & lo_mask);
            idle();
            r_clean = crc_out[31:0];
            step(1, 2'(sz), 32'h1234ABCD, d | ~lo_mask);
            idle();
            r_junk = crc_out[31:0];
            report("R6 upper data ignored", {32'h0, r_junk}, {32'h0, r_clean});
        end

        // R11: check vector by byte-wise streaming with feedback.
        cur_req = "R11";
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            op_valid = 1'b1; op_size = 2'd0;
            crc_in = (i == 0) ? 32'hFFFFFFFF : crc_out[31:0];
            data_in = {56'h0, s[i]};
        end
        idle();
        final_c = ~crc_out[31:0];
        report("R11 check value", {32'h0, final_c}, {32'h0, 32'hE3069283});
        report("R7 upper half", {32'h0, crc_out[63:32]}, 64'h0);

        // R1: mid-run reset clears a nonzero result.
        cur_req = "R1";
        step(1, 2'd3, 32'hDEADBEEF, 64'h0123456789ABCDEF);
        @(negedge clk);
        op_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        report("R1 mid reset crc", crc_out, 64'h0);
        report("R1 mid reset done", {63'h0, done}, 64'h0);
        rst_n = 1'b1; op_valid = 1'b0;
        idle();
        idle();
        running = 1'b0;
        finish_run();
    end
endmodule